// File: doc/BRIEF.md
# PCM Voice Serial Port with Frame-Sync Mode Detection

This block is the digital serial port of a telephony voice codec. Once per 8 kHz frame it sends one 8-bit companded code and receives one 8-bit code. Both go sign bit first. The transmit side drives a data pin through an output enable, so the pad goes high-impedance whenever `tx_oe` is low. The receive side captures a byte from a data input. The bit clock and both frame syncs come from the line side. The block samples them with its own faster system clock through a two-stage synchronizer and detects their edges there, so every flop runs on `clk`.

The block measures the width of the transmit frame sync and picks short or long framing from it. Short framing is a sync one bit period wide. In short framing the slot starts on the bit-clock rising edge after the sync is seen high on a falling edge. In long framing the slot starts at the later of the sync rising edge and a bit-clock rising edge. The end of the slot follows its own rule in each mode. The mode is measured while the sync is high and is updated when the sync falls. A frame uses the mode that is in force when its slot starts. The code to send comes from `tx_code`, which carries the previous encode result. It is latched when the sync is detected, so the slot always carries one whole byte. An active-low time-slot output marks the 8 transmit bits.

Transmit states: IDLE (output off), ARM (sync seen, waiting for the rising edge that enables the output), SHIFT (output on, one bit per rising edge), DRAIN (long framing only: 8 bits sent, output held on until the sync falls). Transitions: IDLE->ARM on a short-mode sync seen at a falling edge, or on a long-mode sync rise while the bit clock is low. IDLE->SHIFT on a long-mode sync rise while the bit clock is high. ARM->SHIFT on a bit-clock rise. SHIFT->IDLE on the falling edge after the eighth bit, unless this is a long frame whose sync is still high, in which case SHIFT->DRAIN. DRAIN->IDLE when the sync is low. Receive states: IDLE, CAPT (capturing on falling edges), DONE (one-cycle strobe). Transitions: IDLE->CAPT on a short-mode sync seen at a falling edge, or on a long-mode sync rise. CAPT->DONE on the eighth capturing falling edge. DONE->IDLE always.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset `tx_oe`=0, `tslot_n`=1, `rx_valid`=0 and `long_mode`=0, which means short framing.
- R2: Consider a transmit sync pulse when it falls. If it covered exactly one bit-clock falling edge, `long_mode` becomes 0. If it covered 3 or more, `long_mode` becomes 1. If it covered 2, `long_mode` keeps its value. `long_mode` changes at no other time.
- R3: Short framing, transmit start. If `fs_tx` is high at a bit-clock falling edge, the next rising edge sets `tx_oe` and drives bit 7 of the byte. Each of the next seven rising edges drives the next lower bit.
- R4: Short framing, transmit end. `tx_oe` goes low at the falling edge that follows the eighth rising edge of the slot.
- R5: Long framing, transmit start. `tx_oe` rises at the later of the `fs_tx` rise and a bit-clock rise. The first bit driven is bit 7, and the seven following rising edges drive bits 6 down to 0.
- R6: Long framing, transmit end. `tx_oe` goes low at the later of two events: the falling edge after the eighth bit is driven, or `fs_tx` going low.
- R7: `tslot_n` is low only from the start of the slot to the falling edge after its eighth bit. Whenever `tslot_n` is low, `tx_oe` is high.
- R8: The byte sent is the value of `tx_code` when the transmit sync is detected. A change to `tx_code` during the slot has no effect on the bits sent.
- R9: Short framing, receive. If `fs_rx` is high at a falling edge, the next eight falling edges sample `rx_din` into bits 7 down to 0.
- R10: Long framing, receive. A rise of `fs_rx` makes the next eight falling edges sample `rx_din` into bits 7 down to 0.
- R11: Each received byte produces one `rx_valid` pulse lasting exactly one `clk` cycle, in the cycle after the eighth capturing falling edge is detected. `rx_byte` holds that byte until the next one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low reset |
| bclk | input | 1 | Line bit clock |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| rx_din | input | 1 | Receive serial data |
| tx_code | input | 8 | Code from the previous encode cycle |
| tx_dout | output | 1 | Transmit serial data, meaningful when tx_oe=1 |
| tx_oe | output | 1 | Output enable for the transmit pad |
| tslot_n | output | 1 | Active-low transmit time-slot indicator |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |
| long_mode | output | 1 | Detected framing: 0 short, 1 long |

## Verification
Frames use sync widths of 1, 2, 3, 4 and 10 bit periods, some starting in short mode and some in long mode. This shows whether the mode follows the previous frame's pulse, whether it updates at the sync fall, and whether a 2-period pulse leaves it unchanged. In some frames the sync rises during the low phase of the bit clock. Against a sync rising together with the clock, this tells "enable at sync rise" apart from "enable at the later of the two edges". A 10-period sync in long mode holds the output on after the eighth bit while `tslot_n` has already returned high. Mid-slot changes to `tx_code` and varied receive bytes show the latching point and the bit order.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARM   = 2'd1,
        TX_SHIFT = 2'd2,
        TX_DRAIN = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_CAPT = 2'd1,
        RX_DONE = 2'd2
    } rx_state_e;

    localparam int SIG_BCLK  = 0;
    localparam int SIG_FSTX  = 1;
    localparam int SIG_FSRX  = 2;
    localparam int SIG_DIN   = 3;
    localparam int SIG_COUNT = 4;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[i]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign lvl[i]  = chain_q[STAGES-1];
        assign rise[i] = chain_q[STAGES-1] & ~prev_q;
        assign fall[i] = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/pcm_mode_detect.sv
module pcm_mode_detect #(
    parameter int LONG_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_fall,
    input  logic fs_lvl,
    input  logic fs_rise,
    input  logic fs_fall,
    output logic long_mode
);
    localparam int CW = $clog2(LONG_MIN + 1);

    logic [CW-1:0] width_q;
    logic          long_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
            long_q  <= 1'b0;
        end else begin
            if (fs_rise) begin
                width_q <= '0;
            end else if (bclk_fall && fs_lvl && (width_q != CW'(LONG_MIN))) begin
                width_q <= width_q + 1'b1;
            end
            if (fs_fall) begin
                if (width_q == CW'(1)) begin
                    long_q <= 1'b0;
                end else if (width_q == CW'(LONG_MIN)) begin
                    long_q <= 1'b1;
                end
            end
        end
    end

    assign long_mode = long_q;

    // R2: framing decision moves only on a sync fall
    a_r2_mode_on_fs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_fall |=> $stable(long_mode));
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
    import pcm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_lvl,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              fs_lvl,
    input  logic              fs_rise,
    input  logic              long_mode,
    input  logic [DATA_W-1:0] tx_code,
    output logic              tx_dout,
    output logic              tx_oe,
    output logic              tslot_n
);
    localparam int CW = $clog2(DATA_W + 1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CW-1:0]     cnt_q;
    logic              flong_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (!long_mode && bclk_fall && fs_lvl) begin
                    state_d = TX_ARM;
                end else if (long_mode && fs_rise) begin
                    state_d = bclk_lvl ? TX_SHIFT : TX_ARM;
                end
            end
            TX_ARM: begin
                if (bclk_rise) state_d = TX_SHIFT;
            end
            TX_SHIFT: begin
                if (bclk_fall && (cnt_q == CW'(DATA_W))) begin
                    state_d = (flong_q && fs_lvl) ? TX_DRAIN : TX_IDLE;
                end
            end
            TX_DRAIN: begin
                if (!fs_lvl) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            flong_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE && state_d != TX_IDLE) begin
                shreg_q <= tx_code;
                flong_q <= long_mode;
            end
            if (state_d == TX_SHIFT && state_q != TX_SHIFT) begin
                cnt_q <= CW'(1);
            end else if (state_q == TX_SHIFT && bclk_rise && (cnt_q < CW'(DATA_W))) begin
                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        tx_oe   = (state_q == TX_SHIFT) || (state_q == TX_DRAIN);
        tslot_n = (state_q != TX_SHIFT);
        tx_dout = shreg_q[DATA_W-1];
    end

    // R7: slot indicator only while the pad is driven
    a_r7_slot_in_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !tslot_n |-> tx_oe);

    // R3: data moves only on a bit-clock rise during the slot
    a_r3_shift_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SHIFT && !bclk_rise) |=> $stable(tx_dout));
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
    import pcm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_fall,
    input  logic              fs_lvl,
    input  logic              fs_rise,
    input  logic              din_lvl,
    input  logic              long_mode,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);
    localparam int CW = $clog2(DATA_W + 1);

    rx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] hold_q;
    logic [CW-1:0]     cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if ((!long_mode && bclk_fall && fs_lvl) || (long_mode && fs_rise)) begin
                    state_d = RX_CAPT;
                end
            end
            RX_CAPT: begin
                if (bclk_fall && (cnt_q == CW'(DATA_W - 1))) state_d = RX_DONE;
            end
            RX_DONE: state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            shreg_q <= '0;
            hold_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RX_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == RX_CAPT && bclk_fall) begin
                shreg_q <= {shreg_q[DATA_W-2:0], din_lvl};
                cnt_q   <= cnt_q + 1'b1;
                if (state_d == RX_DONE) begin
                    hold_q <= {shreg_q[DATA_W-2:0], din_lvl};
                end
            end
        end
    end

    always_comb begin
        rx_valid = (state_q == RX_DONE);
        rx_byte  = hold_q;
    end

    // R11: strobe lasts one cycle
    a_r11_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11: strobe follows a detected falling edge
    a_r11_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bclk_fall));
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LONG_MIN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fs_tx,
    input  logic              fs_rx,
    input  logic              rx_din,
    input  logic [DATA_W-1:0] tx_code,
    output logic              tx_dout,
    output logic              tx_oe,
    output logic              tslot_n,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              long_mode
);
    logic [SIG_COUNT-1:0] raw, lvl, rise, fall;

    always_comb begin
        raw           = '0;
        raw[SIG_BCLK] = bclk;
        raw[SIG_FSTX] = fs_tx;
        raw[SIG_FSRX] = fs_rx;
        raw[SIG_DIN]  = rx_din;
    end

    pcm_edge_sync #(.WIDTH(SIG_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw),
        .lvl      (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    pcm_mode_detect #(.LONG_MIN(LONG_MIN)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_fall (fall[SIG_BCLK]),
        .fs_lvl    (lvl[SIG_FSTX]),
        .fs_rise   (rise[SIG_FSTX]),
        .fs_fall   (fall[SIG_FSTX]),
        .long_mode (long_mode)
    );

    pcm_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_lvl  (lvl[SIG_BCLK]),
        .bclk_rise (rise[SIG_BCLK]),
        .bclk_fall (fall[SIG_BCLK]),
        .fs_lvl    (lvl[SIG_FSTX]),
        .fs_rise   (rise[SIG_FSTX]),
        .long_mode (long_mode),
        .tx_code   (tx_code),
        .tx_dout   (tx_dout),
        .tx_oe     (tx_oe),
        .tslot_n   (tslot_n)
    );

    pcm_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_fall (fall[SIG_BCLK]),
        .fs_lvl    (lvl[SIG_FSRX]),
        .fs_rise   (rise[SIG_FSRX]),
        .din_lvl   (lvl[SIG_DIN]),
        .long_mode (long_mode),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid)
    );
endmodule

// File: tb/tb_pcm_serial_port.sv
module tb_pcm_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0, fs_tx = 1'b0, fs_rx = 1'b0, rx_din = 1'b1;
    logic [7:0] tx_code = 8'h00;
    logic       tx_dout, tx_oe, tslot_n, rx_valid, long_mode;
    logic [7:0] rx_byte;

    int checks = 0, fails = 0, vcnt = 0;
    logic [7:0] vbyte = 8'h00;
    logic model_long = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcm_serial_port dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .rx_din(rx_din), .tx_code(tx_code), .tx_dout(tx_dout), .tx_oe(tx_oe),
        .tslot_n(tslot_n), .rx_byte(rx_byte), .rx_valid(rx_valid), .long_mode(long_mode)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcnt  <= vcnt + 1;
            vbyte <= rx_byte;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // fields: width[3:0], early, tx byte, rx byte
    localparam int NV = 9;
    localparam logic [20:0] VEC [NV] = '{
        {4'd1,  1'b0, 8'hA5, 8'h3C},
        {4'd4,  1'b0, 8'h96, 8'hF0},
        {4'd1,  1'b0, 8'h0F, 8'h81},
        {4'd3,  1'b0, 8'hC3, 8'h7E},
        {4'd4,  1'b1, 8'h5A, 8'h01},
        {4'd10, 1'b0, 8'hFF, 8'h80},
        {4'd2,  1'b0, 8'h00, 8'hAA},
        {4'd1,  1'b1, 8'h81, 8'h55},
        {4'd1,  1'b1, 8'h3C, 8'hC3}
    };

    task automatic run_frame(input int w, input bit early, input logic [7:0] txb,
                             input logic [7:0] rxb);
        bit m;
        int off, last, v0;
        bit e_oe, e_sl;
        m    = model_long;
        off  = m ? 0 : 1;
        last = (w + 1 > 9) ? w + 1 : 9;
        v0   = vcnt;
        tx_code = txb;
        for (int p = -1; p <= last; p++) begin
            bclk  = 1'b1;
            fs_tx = (p >= 0 && p < w);
            fs_rx = (p >= 0 && p < w);
            rx_din = (p >= off && p <= off + 7) ? rxb[7 - (p - off)] : 1'b1;
            if (p == 2) tx_code = ~txb; // R8: late change must not matter
            wclk(6);
            if (m) begin
                e_sl = (p >= 0 && p <= 7);
                e_oe = (p >= 0) && (p <= 7 || p < w);
            end else begin
                e_sl = (p >= 1 && p <= 8);
                e_oe = e_sl;
            end
            chk(m ? "R5/R6 oe high phase" : "R3/R4 oe high phase", {7'd0, tx_oe}, {7'd0, e_oe});
            chk("R7 tslot_n high phase", {7'd0, tslot_n}, {7'd0, !e_sl});
            if (e_sl)
                chk(m ? "R5 R8 data bit" : "R3 R8 data bit", {7'd0, tx_dout},
                    {7'd0, txb[m ? 7 - p : 8 - p]});
            wclk(2);
            bclk = 1'b0;
            wclk(1);
            if (early && p == -1) begin
                fs_tx = 1'b1;
                fs_rx = 1'b1;
            end
            wclk(5);
            if (m) begin
                e_sl = (p >= 0 && p <= 6);
                e_oe = (p >= 0) && (p <= 6 || p < w);
            end else begin
                e_sl = (p >= 1 && p <= 7);
                e_oe = e_sl;
            end
            chk(m ? "R5/R6 oe low phase" : "R3/R4 oe low phase", {7'd0, tx_oe}, {7'd0, e_oe});
            chk("R7 tslot_n low phase", {7'd0, tslot_n}, {7'd0, !e_sl});
            wclk(2);
        end
        wclk(4);
        chk("R11 one strobe per frame", 8'(vcnt - v0), 8'd1);
        chk(m ? "R10 long rx byte" : "R9 short rx byte", vbyte, rxb);
        chk("R11 rx_byte held", rx_byte, rxb);
        if (w == 1) model_long = 1'b0;
        else if (w >= 3) model_long = 1'b1;
        chk("R2 mode after frame", {7'd0, long_mode}, {7'd0, model_long});
    endtask

    initial begin
        wclk(5);
        chk("R1 oe reset", {7'd0, tx_oe}, 8'd0);
        chk("R1 tslot_n reset", {7'd0, tslot_n}, 8'd1);
        chk("R1 valid reset", {7'd0, rx_valid}, 8'd0);
        chk("R1 short default", {7'd0, long_mode}, 8'd0);
        rst_n = 1'b1;
        wclk(20);
        for (int i = 0; i < NV; i++) begin
            run_frame(int'(VEC[i][20:17]), VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
        end
        // directed: switch to long, then reset returns to short (R1, R2)
        run_frame(3, 1'b0, 8'h6E, 8'h19);
        chk("R2 long after width 3", {7'd0, long_mode}, 8'd1);
        rst_n = 1'b0;
        wclk(3);
        chk("R1 reset clears mode", {7'd0, long_mode}, 8'd0);
        chk("R1 reset oe", {7'd0, tx_oe}, 8'd0);
        rst_n = 1'b1;
        model_long = 1'b0;
        wclk(10);
        run_frame(1, 1'b0, 8'hE7, 8'h42);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule